// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive path of an Ethernet MAC. For each frame it looks at the 48-bit destination address and gives a single pass or drop verdict. The address bytes arrive one per accepted byte cycle, first byte first. A start strobe marks the first byte of each frame. While the bytes arrive, the block runs a CRC-32 over them to index a multicast hash table. It also holds the assembled address so it can be compared against a set of exact-match unicast slots.

A simple write port loads a staging copy of the configuration: the filter mode bits, the hash words and the unicast slots. That staging copy is moved into the active copy when a frame starts. A frame is therefore always judged against the configuration that was in force at its first byte. The verdict appears as a one-cycle valid pulse together with the pass flag, one clock after the sixth address byte is accepted.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, `verdict_vld` is low, and `verdict_pass` is low in every cycle where `verdict_vld` is low.
- R2: `verdict_vld` pulses high for exactly one cycle, one clock after the sixth accepted address byte. Idle cycles (`byte_vld` low) between bytes delay the verdict. Bytes without `frame_sof` that follow the sixth byte give no verdict.
- R3: Mode bit 0 (promiscuous) or mode bit 3 (receive-all) makes every frame pass.
- R4: The all-ones address passes unless mode bit 4 (broadcast off) is set. Mode bits 0 and 3 still override mode bit 4.
- R5: Mode bit 1 (all-group) passes every non-broadcast address whose first byte has bit 0 set.
- R6: With mode bit 2 (hash) set, a group address passes when its hash bit is set. To find the index, run a reflected CRC-32 (polynomial 0xEDB88320, seed all ones) over the six bytes, each byte LSB first. Complement the result and reverse its bits. The top log2(HASH_BINS) bits are the index. The index selects hash word index/32, at write address 1+word, and bit index%32 within that word.
- R7: A non-broadcast group address is dropped when neither mode bit 1 nor a set hash bit lets it through.
- R8: An individual address (first byte bit 0 clear) passes when it equals an enabled slot. For slot k, address 16+2k holds bytes 0..3 (byte 0 in bits 7:0). Address 17+2k holds bytes 4..5 in bits 15:0 (byte 4 in bits 7:0), and bit 31 of that word enables the slot. A disabled slot never matches.
- R9: An individual address that matches no enabled slot is dropped.
- R10: Writes to the mode word (address 0, bits 4:0), the hash words or the slots take effect only from the next `frame_sof`. A write made in the middle of a frame does not change that frame's verdict.
- R11: A `frame_sof` byte restarts the address capture. The verdict then reflects only the six bytes counted from that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sof | input | 1 | Marks the first address byte of a frame (sampled with `byte_vld`) |
| byte_vld | input | 1 | `byte_in` carries an address byte this cycle |
| byte_in | input | 8 | Destination address byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| verdict_vld | output | 1 | One-cycle verdict strobe |
| verdict_pass | output | 1 | Frame accepted when high with `verdict_vld` |

## Verification
Addresses are drawn from four classes: slot copies, the broadcast address, random group addresses and random individual addresses. Each class is run against random mode words, hash words and slot enables, and the outcome is compared with a reference decision function. Directed cases pin down the details. One pair of group addresses has distinct hash indices, so a wrong CRC bit order or index mapping shows up as a wrong verdict. An enabled slot and a disabled slot holding the same kind of address separate the compare path from the enable path. Frames sent with gaps, extra trailing bytes and a restarted start strobe show whether the byte counting is right. A mode write made in the middle of a frame shows whether the configuration is sampled at frame start.

// File: rtl/aflt_pkg.sv
package aflt_pkg;

  localparam int unsigned CFG_AW = 6;
  localparam int unsigned MODE_ADDR = 0;
  localparam int unsigned HASH_BASE = 1;
  localparam int unsigned SLOT_BASE = 16;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam int unsigned ADDR_BYTES = 6;

  // packed: bcast_off is bit 4, promisc is bit 0
  typedef struct packed {
    logic bcast_off;
    logic rx_all;
    logic hash_en;
    logic all_grp;
    logic promisc;
  } mode_t;

  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      c = (c >> 1) ^ (((c[0] ^ d[b]) != 1'b0) ? CRC_POLY_R : 32'h0);
    end
    return c;
  endfunction

endpackage

// File: rtl/aflt_crc_acc.sv
module aflt_crc_acc
  import aflt_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sof,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  output logic             last_byte,
  output logic [47:0]      full_addr,
  output logic [IDX_W-1:0] hash_idx
);

  localparam logic [2:0] IDLE_CNT = 3'(ADDR_BYTES);

  logic [2:0]  cnt_q, cnt_d;
  logic [31:0] crc_q, crc_d;
  logic [39:0] addr_q, addr_d;
  logic [2:0]  pos;
  logic        take;
  logic [31:0] crc_base;
  logic [31:0] crc_new;

  always_comb begin
    pos      = frame_sof ? 3'd0 : cnt_q;
    take     = byte_vld && (frame_sof || (cnt_q != IDLE_CNT));
    crc_base = frame_sof ? 32'hFFFF_FFFF : crc_q;
    crc_new  = crc_step_byte(crc_base, byte_in);
    cnt_d    = cnt_q;
    crc_d    = crc_q;
    addr_d   = addr_q;
    if (take) begin
      cnt_d = pos + 3'd1;
      crc_d = crc_new;
      if (pos < 3'd5) begin
        addr_d[{pos, 3'b000} +: 8] = byte_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= IDLE_CNT;
      crc_q  <= '1;
      addr_q <= '0;
    end else if (take) begin
      cnt_q  <= cnt_d;
      crc_q  <= crc_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    last_byte = take && (pos == 3'd5);
    full_addr = {byte_in, addr_q};
    hash_idx  = '0;
    for (int i = 0; i < int'(IDX_W); i++) begin
      hash_idx[IDX_W-1-i] = ~crc_new[i];
    end
  end

endmodule

// File: rtl/aflt_cfg_regs.sv
module aflt_cfg_regs
  import aflt_pkg::*;
#(
  parameter int unsigned HASH_WORDS = 2,
  parameter int unsigned NUM_SLOTS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [31:0]               cfg_wdata,
  input  logic                      snap,
  output mode_t                     act_mode,
  output logic [HASH_WORDS*32-1:0]  act_hash,
  output logic [NUM_SLOTS*48-1:0]   act_saddr,
  output logic [NUM_SLOTS-1:0]      act_sen
);

  mode_t                    stg_mode_q, stg_mode_d;
  logic [HASH_WORDS*32-1:0] stg_hash_q, stg_hash_d;
  logic [NUM_SLOTS*48-1:0]  stg_saddr_q, stg_saddr_d;
  logic [NUM_SLOTS-1:0]     stg_sen_q, stg_sen_d;

  always_comb begin
    stg_mode_d  = stg_mode_q;
    stg_hash_d  = stg_hash_q;
    stg_saddr_d = stg_saddr_q;
    stg_sen_d   = stg_sen_q;
    if (cfg_we) begin
      if (cfg_addr == CFG_AW'(MODE_ADDR)) begin
        stg_mode_d = mode_t'(cfg_wdata[4:0]);
      end
      for (int w = 0; w < int'(HASH_WORDS); w++) begin
        if (cfg_addr == CFG_AW'(int'(HASH_BASE) + w)) begin
          stg_hash_d[w*32 +: 32] = cfg_wdata;
        end
      end
      for (int k = 0; k < int'(NUM_SLOTS); k++) begin
        if (cfg_addr == CFG_AW'(int'(SLOT_BASE) + 2*k)) begin
          stg_saddr_d[k*48 +: 32] = cfg_wdata;
        end
        if (cfg_addr == CFG_AW'(int'(SLOT_BASE) + 2*k + 1)) begin
          stg_saddr_d[k*48+32 +: 16] = cfg_wdata[15:0];
          stg_sen_d[k]               = cfg_wdata[31];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_mode_q  <= '0;
      stg_hash_q  <= '0;
      stg_saddr_q <= '0;
      stg_sen_q   <= '0;
    end else if (cfg_we) begin
      stg_mode_q  <= stg_mode_d;
      stg_hash_q  <= stg_hash_d;
      stg_saddr_q <= stg_saddr_d;
      stg_sen_q   <= stg_sen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode  <= '0;
      act_hash  <= '0;
      act_saddr <= '0;
      act_sen   <= '0;
    end else if (snap) begin
      act_mode  <= stg_mode_q;
      act_hash  <= stg_hash_q;
      act_saddr <= stg_saddr_q;
      act_sen   <= stg_sen_q;
    end
  end

endmodule

// File: rtl/aflt_slot_match.sv
module aflt_slot_match #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [47:0]             addr,
  input  logic [NUM_SLOTS*48-1:0] slot_addr,
  input  logic [NUM_SLOTS-1:0]    slot_en,
  output logic                    hit
);

  logic [NUM_SLOTS-1:0] slot_hit;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slot_hit[k] = slot_en[k] && (slot_addr[k*48 +: 48] == addr);
  end

  assign hit = |slot_hit;

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import aflt_pkg::*;
#(
  parameter int unsigned HASH_BINS = 64,
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sof,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              verdict_vld,
  output logic              verdict_pass
);

  localparam int unsigned HASH_WORDS = HASH_BINS / 32;
  localparam int unsigned IDX_W      = $clog2(HASH_BINS);

  mode_t                    act_mode;
  logic [HASH_WORDS*32-1:0] act_hash;
  logic [NUM_SLOTS*48-1:0]  act_saddr;
  logic [NUM_SLOTS-1:0]     act_sen;
  logic                     snap;
  logic                     last_byte;
  logic [47:0]              full_addr;
  logic [IDX_W-1:0]         hash_idx;
  logic                     slot_hit;
  logic                     hash_hit;
  logic                     is_bcast;
  logic                     is_group;
  logic                     pass_d;
  logic                     vld_q, pass_q;

  assign snap = byte_vld && frame_sof;

  aflt_cfg_regs #(
    .HASH_WORDS(HASH_WORDS),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .snap     (snap),
    .act_mode (act_mode),
    .act_hash (act_hash),
    .act_saddr(act_saddr),
    .act_sen  (act_sen)
  );

  aflt_crc_acc #(
    .IDX_W(IDX_W)
  ) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_sof(frame_sof),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .last_byte(last_byte),
    .full_addr(full_addr),
    .hash_idx (hash_idx)
  );

  aflt_slot_match #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_slots (
    .addr     (full_addr),
    .slot_addr(act_saddr),
    .slot_en  (act_sen),
    .hit      (slot_hit)
  );

  always_comb begin
    hash_hit = act_hash[hash_idx];
    is_bcast = &full_addr;
    is_group = full_addr[0];
    if (act_mode.promisc || act_mode.rx_all) begin
      pass_d = 1'b1;
    end else if (is_bcast) begin
      pass_d = !act_mode.bcast_off;
    end else if (is_group) begin
      pass_d = act_mode.all_grp || (act_mode.hash_en && hash_hit);
    end else begin
      pass_d = slot_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      vld_q  <= last_byte;
      pass_q <= last_byte && pass_d;
    end
  end

  assign verdict_vld  = vld_q;
  assign verdict_pass = pass_q;

endmodule

// File: rtl/aflt_chk.sv
module aflt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_sof,
  input logic       byte_vld,
  input logic       verdict_vld,
  input logic       verdict_pass,
  input logic [4:0] act_mode_bits
);

  a_r1_pass_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_vld |-> !verdict_pass);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld);

  a_r2_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> $past(byte_vld));

  a_r3_open_modes_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(act_mode_bits[0] || act_mode_bits[3])) |-> verdict_pass);

  a_r10_cfg_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && frame_sof) |=> $stable(act_mode_bits));

endmodule

bind eth_rx_addr_filter aflt_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_sof    (frame_sof),
  .byte_vld     (byte_vld),
  .verdict_vld  (verdict_vld),
  .verdict_pass (verdict_pass),
  .act_mode_bits(act_mode)
);

// File: tb/eth_rx_addr_filter_bench.sv
module eth_rx_addr_filter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HB  = 128;
  localparam int NS  = 4;
  localparam int HW  = HB / 32;
  localparam int IXW = $clog2(HB);
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  logic        clk, rst_n;
  logic        frame_sof, byte_vld;
  logic [7:0]  byte_in;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        verdict_vld, verdict_pass;

  int total, bad;
  bit finished;

  logic [4:0]  m_mode;
  logic [31:0] m_hash [HW];
  logic [47:0] m_saddr [NS];
  logic        m_sen [NS];

  eth_rx_addr_filter #(.HASH_BINS(HB), .NUM_SLOTS(NS)) u_eth_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .frame_sof(frame_sof), .byte_vld(byte_vld),
    .byte_in(byte_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .verdict_vld(verdict_vld),
    .verdict_pass(verdict_pass)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [47:0] a);
    logic [31:0] c, r, rv;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 48; b++) begin
      fb = c[0] ^ a[b];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    r = ~c;
    for (int i = 0; i < 32; i++) rv[31-i] = r[i];
    return int'(rv >> (32 - IXW));
  endfunction

  function automatic logic model(input logic [47:0] a);
    int ix;
    logic hit;
    if (m_mode[0] || m_mode[3]) return 1'b1;
    if (a == BCAST) return !m_mode[4];
    if (a[0]) begin
      ix = idx_of(a);
      return m_mode[1] || (m_mode[2] && m_hash[ix/32][ix%32]);
    end
    hit = 1'b0;
    for (int k = 0; k < NS; k++) if (m_sen[k] && m_saddr[k] == a) hit = 1'b1;
    return hit;
  endfunction

  task automatic cfg_write(input int adr, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(adr); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mode(input logic [4:0] v);
    cfg_write(0, {27'd0, v});
    m_mode = v;
  endtask

  task automatic set_hash(input int w, input logic [31:0] v);
    cfg_write(1 + w, v);
    m_hash[w] = v;
  endtask

  task automatic set_slot(input int k, input logic [47:0] a, input logic en);
    cfg_write(16 + 2*k, a[31:0]);
    cfg_write(17 + 2*k, {en, 15'd0, a[47:32]});
    m_saddr[k] = a; m_sen[k] = en;
  endtask

  // sends six bytes; optional mode write together with byte 2
  task automatic run_frame(input logic [47:0] a, input int gap, input logic exp,
                           input string req, input int mid_mode);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byte_vld = 1'b1; frame_sof = (i == 0); byte_in = a[8*i +: 8];
      cfg_we = 1'b0;
      if (i == 2 && mid_mode >= 0) begin
        cfg_we = 1'b1; cfg_addr = 6'd0; cfg_wdata = 32'(mid_mode);
      end
      if (i < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          byte_vld = 1'b0; frame_sof = 1'b0; cfg_we = 1'b0;
          chk("R2 no verdict inside gap", {31'd0, verdict_vld}, 32'd0);
        end
      end
    end
    @(negedge clk);
    byte_vld = 1'b0; frame_sof = 1'b0; cfg_we = 1'b0;
    chk("R2 verdict strobe", {31'd0, verdict_vld}, 32'd1);
    chk(req, {31'd0, verdict_pass}, {31'd0, exp});
    @(negedge clk);
    chk("R2 strobe one cycle", {31'd0, verdict_vld}, 32'd0);
  endtask

  function automatic logic [47:0] rnd_addr();
    return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] ua, ub, uc, mg, mg2, a;
    int seed, im, cat, k;
    string lbl;
    seed = $urandom(32'h5EED_0042);
    total = 0; bad = 0; finished = 1'b0;
    rst_n = 1'b0; frame_sof = 1'b0; byte_vld = 1'b0; byte_in = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    m_mode = '0;
    for (int w = 0; w < HW; w++) m_hash[w] = '0;
    for (int s = 0; s < NS; s++) begin m_saddr[s] = '0; m_sen[s] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", {31'd0, verdict_vld}, 32'd0);
    chk("R1 reset pass", {31'd0, verdict_pass}, 32'd0);

    // unicast slots
    ua = rnd_addr() & ~48'h1; ub = rnd_addr() & ~48'h1; uc = rnd_addr() & ~48'h1;
    set_mode(5'b00000);
    set_slot(0, ua, 1'b1);
    set_slot(1, ub, 1'b0);
    run_frame(ua, 0, 1'b1, "R8 enabled slot match", -1);
    run_frame(ub, 0, 1'b0, "R8 disabled slot ignored", -1);
    run_frame(uc, 0, 1'b0, "R9 unknown unicast dropped", -1);

    // broadcast
    run_frame(BCAST, 0, 1'b1, "R4 broadcast passes", -1);
    set_mode(5'b10000);
    run_frame(BCAST, 0, 1'b0, "R4 broadcast off", -1);
    set_mode(5'b10001);
    run_frame(BCAST, 0, 1'b1, "R3 promisc beats broadcast off", -1);
    run_frame(uc, 1, 1'b1, "R3 promisc unicast", -1);

    // group addresses and hash
    mg = rnd_addr() | 48'h1;
    im = idx_of(mg);
    do begin mg2 = rnd_addr() | 48'h1; end while (idx_of(mg2) == im);
    set_mode(5'b00000);
    run_frame(mg, 0, 1'b0, "R7 group dropped", -1);
    set_mode(5'b00010);
    run_frame(mg, 0, 1'b1, "R5 all-group passes", -1);
    set_mode(5'b00100);
    for (int w = 0; w < HW; w++) set_hash(w, (w == im/32) ? (32'h1 << (im%32)) : 32'h0);
    run_frame(mg, 0, 1'b1, "R6 hash bit hit", -1);
    run_frame(mg2, 2, 1'b0, "R6 hash bit miss", -1);
    set_mode(5'b01000);
    run_frame(uc, 0, 1'b1, "R3 receive-all", -1);

    // trailing bytes after a frame give no verdict
    set_mode(5'b00000);
    run_frame(ua, 0, 1'b1, "R8 slot again", -1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_vld = 1'b1; frame_sof = 1'b0; byte_in = 8'($urandom);
      @(negedge clk); byte_vld = 1'b0;
      chk("R2 trailing byte no verdict", {31'd0, verdict_vld}, 32'd0);
    end

    // restart mid-address
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_vld = 1'b1; frame_sof = (i == 0); byte_in = uc[8*i +: 8];
      @(negedge clk); byte_vld = 1'b0; frame_sof = 1'b0;
      chk("R11 partial frame no verdict", {31'd0, verdict_vld}, 32'd0);
    end
    run_frame(ua, 0, 1'b1, "R11 restart uses new bytes", -1);

    // mode write inside a frame
    run_frame(uc, 0, 1'b0, "R10 mid-frame write ignored", 1);
    m_mode = 5'b00001;
    run_frame(uc, 0, 1'b1, "R10 write applies at next start", -1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 4 == 0) begin
        logic [4:0] mv;
        mv = 5'($urandom);
        if ($urandom % 4 != 0) mv = mv & 5'b10110;
        set_mode(mv);
        set_hash(int'($urandom % HW), $urandom);
        k = int'($urandom % NS);
        set_slot(k, rnd_addr() & ~48'h1, 1'($urandom));
      end
      cat = int'($urandom % 4);
      case (cat)
        0: begin a = m_saddr[$urandom % NS]; lbl = "R8 random slot address"; end
        1: begin a = BCAST; lbl = "R4 random broadcast"; end
        2: begin a = rnd_addr() | 48'h1; lbl = "R6 random group"; end
        default: begin a = rnd_addr() & ~48'h1; lbl = "R9 random unicast"; end
      endcase
      run_frame(a, int'($urandom % 3), model(a), lbl, -1);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule